// File: doc/BRIEF.md
# Dual-Mode Stack Pointer Unit

This block holds the stack pointer of a small 8-bit processor core. The pointer is always 16 bits wide. It runs in one of two modes. In narrow mode only the low byte moves, so the stack stays inside one fixed 256-byte page. In wide mode the whole 16-bit value moves, and steps carry into or borrow from the high byte. A stack-size flag selects the mode. That flag is the sixth bit (bit 5) of the core's status byte, and the block exports it on its own pin.

An external sequencer drives one strobe per operation:

- push and pull steps,
- a load of the low byte from the X register,
- a load of the high byte from the Y register,
- a set or clear of the stack-size flag.

The current pointer is always on the address output. The sequencer uses it for stack memory accesses and reads it back for transfers into X or Y. A push writes at the current address and then steps down. A pull steps up and then reads at the new address. A two-byte word push is two push strobes on consecutive cycles.

Top module: `spu_stack_ptr`

## Requirements
- R1: After synchronous reset the pointer is 16'h01FF, the stack-size flag is 0 (narrow) and the error output is 0.
- R2: A set or clear strobe on the flag changes `stack_wide` exactly two rising edges after the strobe cycle. A step taken before that edge uses the old mode.
- R3: In narrow mode a push decrements only the low byte, wrapping from 8'h00 to 8'hFF. The high byte is unchanged, so 16'h0100 becomes 16'h01FF.
- R4: In wide mode push and pull act on the full 16 bits. A push at 16'h0100 gives 16'h00FF, and a pull at 16'h00FF gives 16'h0100.
- R5: In narrow mode a pull increments only the low byte, wrapping from 8'hFF to 8'h00. 16'h01FF becomes 16'h0100.
- R6: Push and pull strobed in the same cycle leave the pointer unchanged, and `err` is 1 for exactly the following cycle.
- R7: Set and clear strobed in the same cycle leave the flag unchanged, and `err` is 1 for the following cycle.
- R8: A low-byte load copies `x_in` into bits 7:0 at the next edge and leaves bits 15:8 unchanged.
- R9: A high-byte load copies `y_in` into bits 15:8 at the next edge (one cycle) and leaves bits 7:0 unchanged.
- R10: When any byte load is strobed, a push or pull in the same cycle is not applied.
- R11: Pushes on consecutive cycles step the pointer once per cycle, so a two-byte push moves it by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Step down after the current write |
| pull_i | input | 1 | Step up before the read |
| ld_lo_i | input | 1 | Load pointer low byte from X |
| ld_hi_i | input | 1 | Load pointer high byte from Y |
| wide_set_i | input | 1 | Set the stack-size flag |
| wide_clr_i | input | 1 | Clear the stack-size flag |
| x_in | input | 8 | X register value |
| y_in | input | 8 | Y register value |
| sp_addr | output | 16 | Current stack pointer / stack address |
| stack_wide | output | 1 | Stack-size flag (status bit 5), 1 = wide |
| err | output | 1 | Conflicting strobes seen in the previous cycle |

## Verification
The pointer is a register that drives `sp_addr` directly, so a wrong step or a wrong byte lane shows on the address one edge after the strobe. If the mode is tracked wrongly, the fault stays hidden until a step crosses a page boundary. At that step the high byte moves when it should not, or stays when it should move. For that reason the bench places its wrap tests exactly at 8'h00 and 8'hFF. A bad mode-delay pipeline shows as `stack_wide` changing one edge early or late. It is checked at both edges around the switch and by a step taken in between.

// File: rtl/spu_pkg.sv
package spu_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_DEC  = 2'd1,
    STEP_INC  = 2'd2
  } step_e;
endpackage

// File: rtl/spu_step.sv
module spu_step #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic [AW-1:0]    ptr_i,
  input  spu_pkg::step_e   op_i,
  input  logic             wide_i,
  output logic [AW-1:0]    ptr_o
);
  logic [AW-1:0] full_v;
  logic [LW-1:0] low_v;

  always_comb begin
    full_v = ptr_i;
    low_v  = ptr_i[LW-1:0];
    if (op_i == spu_pkg::STEP_DEC) begin
      full_v = ptr_i - AW'(1);
      low_v  = ptr_i[LW-1:0] - LW'(1);
    end else if (op_i == spu_pkg::STEP_INC) begin
      full_v = ptr_i + AW'(1);
      low_v  = ptr_i[LW-1:0] + LW'(1);
    end
    ptr_o = wide_i ? full_v : {ptr_i[AW-1:LW], low_v};
  end
endmodule

// File: rtl/spu_mode_ctl.sv
module spu_mode_ctl #(
  parameter int   LAT      = 2,
  parameter logic RST_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic wide_o,
  output logic clash_o
);
  localparam int STAGES = (LAT < 2) ? 1 : LAT - 1;

  logic [STAGES-1:0] pend_v;
  logic [STAGES-1:0] pend_d;
  logic              wide_q;

  assign clash_o = set_i & clr_i;
  assign wide_o  = wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= '0;
      pend_d <= '0;
      wide_q <= RST_MODE;
    end else begin
      pend_v[0] <= set_i ^ clr_i;
      pend_d[0] <= set_i;
      for (int i = 1; i < STAGES; i++) begin
        pend_v[i] <= pend_v[i-1];
        pend_d[i] <= pend_d[i-1];
      end
      if (pend_v[STAGES-1]) wide_q <= pend_d[STAGES-1];
    end
  end
endmodule

// File: rtl/spu_stack_ptr.sv
module spu_stack_ptr #(
  parameter int          AW       = 16,
  parameter int          LW       = 8,
  parameter int          MODE_LAT = 2,
  parameter logic [15:0] RST_PTR  = 16'h01FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pull_i,
  input  logic          ld_lo_i,
  input  logic          ld_hi_i,
  input  logic          wide_set_i,
  input  logic          wide_clr_i,
  input  logic [LW-1:0] x_in,
  input  logic [LW-1:0] y_in,
  output logic [AW-1:0] sp_addr,
  output logic          stack_wide,
  output logic          err
);
  localparam int HW = AW - LW;

  logic [AW-1:0]  sp_q;
  logic [AW-1:0]  stepped;
  logic [AW-1:0]  sp_n;
  logic           step_clash;
  logic           mode_clash;
  logic           err_q;
  spu_pkg::step_e op;

  assign step_clash = push_i & pull_i;

  always_comb begin
    op = spu_pkg::STEP_HOLD;
    if (!(ld_lo_i | ld_hi_i) && (push_i ^ pull_i))
      op = push_i ? spu_pkg::STEP_DEC : spu_pkg::STEP_INC;
  end

  spu_mode_ctl #(.LAT(MODE_LAT), .RST_MODE(1'b0)) u_mode (
    .clk(clk), .rst(rst), .set_i(wide_set_i), .clr_i(wide_clr_i),
    .wide_o(stack_wide), .clash_o(mode_clash)
  );

  spu_step #(.AW(AW), .LW(LW)) u_step (
    .ptr_i(sp_q), .op_i(op), .wide_i(stack_wide), .ptr_o(stepped)
  );

  always_comb begin
    sp_n = stepped;
    if (ld_lo_i) sp_n[LW-1:0]  = x_in;
    if (ld_hi_i) sp_n[AW-1:LW] = y_in[HW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= AW'(RST_PTR);
      err_q <= 1'b0;
    end else begin
      sp_q  <= sp_n;
      err_q <= step_clash | mode_clash;
    end
  end

  assign sp_addr = sp_q;
  assign err     = err_q;
endmodule

// File: rtl/spu_stack_ptr_chk.sv
module spu_stack_ptr_chk #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          push_i,
  input logic          pull_i,
  input logic          ld_lo_i,
  input logic          ld_hi_i,
  input logic [LW-1:0] y_in,
  input logic [AW-1:0] sp_addr,
  input logic          stack_wide,
  input logic          err
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (sp_addr == AW'(16'h01FF)) && !stack_wide && !err);

  // R6
  step_clash_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && pull_i && !ld_lo_i && !ld_hi_i) |=> err && $stable(sp_addr));

  // R3
  narrow_push_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pull_i && !ld_lo_i && !ld_hi_i && !stack_wide) |=>
      (sp_addr[AW-1:LW] == $past(sp_addr[AW-1:LW])) &&
      (sp_addr[LW-1:0] == $past(sp_addr[LW-1:0]) - LW'(1)));

  // R4
  wide_push_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pull_i && !ld_lo_i && !ld_hi_i && stack_wide) |=>
      (sp_addr == $past(sp_addr) - AW'(1)));

  // R9
  hi_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_hi_i && !ld_lo_i) |=>
      (sp_addr[LW-1:0] == $past(sp_addr[LW-1:0])) &&
      (sp_addr[AW-1:LW] == $past(y_in[AW-LW-1:0])));
endmodule

bind spu_stack_ptr spu_stack_ptr_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .push_i(push_i), .pull_i(pull_i),
  .ld_lo_i(ld_lo_i), .ld_hi_i(ld_hi_i), .y_in(y_in),
  .sp_addr(sp_addr), .stack_wide(stack_wide), .err(err)
);

// File: tb/spu_stack_ptr_tb.sv
module spu_stack_ptr_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_i = 0, pull_i = 0, ld_lo_i = 0, ld_hi_i = 0;
  logic wide_set_i = 0, wide_clr_i = 0;
  logic [7:0] x_in = 0, y_in = 0;
  logic [15:0] sp_addr;
  logic stack_wide, err;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spu_stack_ptr u_dut (
    .clk(clk), .rst(rst), .push_i(push_i), .pull_i(pull_i),
    .ld_lo_i(ld_lo_i), .ld_hi_i(ld_hi_i), .wide_set_i(wide_set_i),
    .wide_clr_i(wide_clr_i), .x_in(x_in), .y_in(y_in),
    .sp_addr(sp_addr), .stack_wide(stack_wide), .err(err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive strobes for one cycle, sample 1 time unit after the edge
  task automatic cyc(input logic pu, input logic pl, input logic lo, input logic hi,
                     input logic st, input logic cl, input logic [7:0] xv, input logic [7:0] yv);
    push_i = pu; pull_i = pl; ld_lo_i = lo; ld_hi_i = hi;
    wide_set_i = st; wide_clr_i = cl; x_in = xv; y_in = yv;
    @(posedge clk); #1;
    push_i = 0; pull_i = 0; ld_lo_i = 0; ld_hi_i = 0;
    wide_set_i = 0; wide_clr_i = 0;
  endtask

  task automatic load(input logic [15:0] v);
    cyc(0, 0, 1, 1, 0, 0, v[7:0], v[15:8]);
  endtask

  task automatic t_reset();
    chk("R1 ptr", sp_addr, 16'h01FF);
    chk("R1 mode", {15'd0, stack_wide}, 16'd0);
    chk("R1 err", {15'd0, err}, 16'd0);
  endtask

  task automatic t_narrow();
    load(16'h0100);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 push wrap", sp_addr, 16'h01FF);
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    chk("R5 pull wrap", sp_addr, 16'h0100);
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    chk("R5 pull step", sp_addr, 16'h0101);
  endtask

  task automatic t_conflict();
    load(16'h0140);
    cyc(1, 1, 0, 0, 0, 0, 0, 0);
    chk("R6 ptr held", sp_addr, 16'h0140);
    chk("R6 err", {15'd0, err}, 16'd1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 err one cycle", {15'd0, err}, 16'd0);
    cyc(0, 0, 0, 0, 1, 1, 0, 0);
    chk("R7 err", {15'd0, err}, 16'd1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 mode kept", {15'd0, stack_wide}, 16'd0);
  endtask

  task automatic t_mode();
    load(16'h0301);
    cyc(1, 0, 0, 0, 1, 0, 0, 0);
    chk("R2 mode after edge 1", {15'd0, stack_wide}, 16'd0);
    chk("R2 step edge 1", sp_addr, 16'h0300);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 mode after edge 2", {15'd0, stack_wide}, 16'd1);
    chk("R2 step old mode", sp_addr, 16'h03FF);
  endtask

  task automatic t_wide();
    load(16'h0100);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 push borrow", sp_addr, 16'h00FF);
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    chk("R4 pull carry", sp_addr, 16'h0100);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R11 word push", sp_addr, 16'h00FE);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 clear", {15'd0, stack_wide}, 16'd0);
  endtask

  task automatic t_transfer();
    load(16'h1234);
    cyc(0, 0, 1, 0, 0, 0, 8'hA5, 8'h77);
    chk("R8 lo load", sp_addr, 16'h12A5);
    cyc(0, 0, 0, 1, 0, 0, 8'h00, 8'h5C);
    chk("R9 hi load", sp_addr, 16'h5CA5);
    cyc(1, 0, 1, 0, 0, 0, 8'h10, 8'h00);
    chk("R10 push suppressed", sp_addr, 16'h5C10);
    cyc(0, 1, 0, 1, 0, 0, 8'h00, 8'h02);
    chk("R10 pull suppressed", sp_addr, 16'h0210);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R11 narrow word push", sp_addr, 16'h020E);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_narrow();
    t_conflict();
    t_mode();
    t_wide();
    t_transfer();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule